// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer that joins two unrelated clock domains. A producer writes 18-bit words on its own clock and a consumer reads them on another. Active-low status outputs report empty, full, half-full, almost-empty and almost-full. The two almost thresholds are configuration values. They are written and read back over the ordinary data buses while a load strobe is held low. A retransmit strobe sends the read side back to the first location so that a stored block can be replayed.

Each pointer crosses to the other domain as Gray code through a two-flop synchroniser. Empty is derived in the read domain and full in the write domain. A mode input picks the almost-flag timing: either registered in their own domains, or decoded straight from both raw pointers.

Top module: `dcfifo_pflag`

## Requirements
- R1: After reset, empty_n=0, full_n=1, half_n=1, aempty_n=0 and afull_n=1. Both offsets hold 7, and the next offset access selects the empty-offset field.
- R2: Words accepted on wr_clk (wr_en_n=0, load_n=1, not full) come out on dout in the same order, one per rd_clk edge with rd_en_n=0, load_n=1 and not empty. dout changes on the edge that pops the word.
- R3: full_n goes low once DEPTH words are held. A write attempted while full stores nothing and leaves the stored data and the order intact.
- R4: A read attempted while empty leaves dout and the read pointer unchanged. Later data is still delivered correctly.
- R5: While load_n=0, each wr_clk edge with wr_en_n=0 writes din[AW-1:0] into an offset field instead of memory. The fields alternate: empty offset first, then full offset.
- R6: While load_n=0, each rd_clk edge with rd_en_n=0 puts an offset on dout, zero-extended to 18 bits. The fields alternate: empty offset first, then full offset. The buffer is not popped.
- R7: aempty_n is low when the fill level is at or below the empty offset.
- R8: afull_n is low when the free space (DEPTH minus fill level) is at or below the full offset.
- R9: With async_flags=1, the almost flags reflect a write in the same write cycle. With async_flags=0, aempty_n is registered on rd_clk after pointer synchronisation, and afull_n is registered on wr_clk, so both lag.
- R10: half_n is low exactly when the fill level exceeds DEPTH/2.
- R11: A rd_clk edge with retx_n=0 returns the read pointer to location 0, so the words from the first stored location are read again. It has priority over a read.

Ports are listed in declaration order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_n | input | 1 | Active-low write enable |
| din | input | 18 | Write data / offset value |
| rd_en_n | input | 1 | Active-low read enable |
| dout | output | 18 | Read data / offset readback |
| load_n | input | 1 | Active-low redirect of both ports to the offset register |
| retx_n | input | 1 | Active-low retransmit strobe, sampled on rd_clk |
| async_flags | input | 1 | 1: combinational almost flags, 0: registered almost flags |
| empty_n | output | 1 | Low when empty (read domain) |
| full_n | output | 1 | Low when full (write domain) |
| half_n | output | 1 | Low when more than half full (write domain) |
| aempty_n | output | 1 | Almost-empty flag, active low |
| afull_n | output | 1 | Almost-full flag, active low |

## Verification
On every cycle, the assertions check the following:
- a write while full or while loading never moves the write pointer;
- a read while empty never moves the read pointer;
- the write-side Gray pointer changes by at most one bit per edge;
- full implies half-full;
- retransmit clears the read pointer.

Only the bench scenarios can show the rest: data ordering across the two clocks, the threshold crossings of the almost and half flags, the offset field sequence on load, the replay after retransmit, and the one-cycle difference between the two flag timing modes.

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int WIDTH   = 18,
  parameter int DEPTH   = 256,
  parameter int OFF_RST = 7
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             rst_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] dout,
  input  logic             load_n,
  input  logic             retx_n,
  input  logic             async_flags,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             aempty_n,
  output logic             afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, wgray, rptr, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic [AW-1:0] eoff, foff;
  logic          wsel, rsel, aempty_q, afull_q;
  logic [PW-1:0] lvl_w, lvl_r, lvl_a, free_w, free_a;
  logic [PW-1:0] wnext, rnext;

  assign wnext  = wptr + 1'b1;
  assign rnext  = rptr + 1'b1;
  assign lvl_w  = wptr - g2b(rq2);
  assign lvl_r  = g2b(wq2) - rptr;
  assign lvl_a  = wptr - rptr;
  assign free_w = PW'(DEPTH) - lvl_w;
  assign free_a = PW'(DEPTH) - lvl_a;

  assign full_n   = (lvl_w != PW'(DEPTH));
  assign half_n   = ~(lvl_w > PW'(DEPTH / 2));
  assign empty_n  = (lvl_r != '0);
  assign aempty_n = async_flags ? ~(lvl_a <= {1'b0, eoff}) : aempty_q;
  assign afull_n  = async_flags ? ~(free_a <= {1'b0, foff}) : afull_q;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
      eoff <= AW'(OFF_RST); foff <= AW'(OFF_RST);
      wsel <= 1'b0; afull_q <= 1'b1;
    end else begin
      rq1 <= rgray; rq2 <= rq1;
      afull_q <= ~(free_w <= {1'b0, foff});
      if (!wr_en_n) begin
        if (!load_n) begin
          if (wsel) foff <= din[AW-1:0];
          else      eoff <= din[AW-1:0];
          wsel <= ~wsel;
        end else if (full_n) begin
          wptr  <= wnext;
          wgray <= wnext ^ (wnext >> 1);
        end
      end
    end
  end

  always_ff @(posedge wr_clk)
    if (!wr_en_n && load_n && full_n) mem[wptr[AW-1:0]] <= din;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      rsel <= 1'b0; aempty_q <= 1'b0; dout <= '0;
    end else begin
      wq1 <= wgray; wq2 <= wq1;
      aempty_q <= ~(lvl_r <= {1'b0, eoff});
      if (!retx_n) begin
        rptr <= '0; rgray <= '0;
      end else if (!rd_en_n) begin
        if (!load_n) begin
          dout <= {{(WIDTH-AW){1'b0}}, (rsel ? foff : eoff)};
          rsel <= ~rsel;
        end else if (empty_n) begin
          dout  <= mem[rptr[AW-1:0]];
          rptr  <= rnext;
          rgray <= rnext ^ (rnext >> 1);
        end
      end
    end
  end
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
  parameter int DEPTH = 256
) (
  input logic                     wr_clk,
  input logic                     rd_clk,
  input logic                     rst_n,
  input logic                     wr_en_n,
  input logic                     rd_en_n,
  input logic                     load_n,
  input logic                     retx_n,
  input logic                     full_n,
  input logic                     empty_n,
  input logic                     half_n,
  input logic [$clog2(DEPTH):0]   wptr,
  input logic [$clog2(DEPTH):0]   wgray,
  input logic [$clog2(DEPTH):0]   rptr
);
  p_full_hold_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && !wr_en_n) |=> $stable(wptr));

  p_load_wptr_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !load_n |=> $stable(wptr));

  p_gray_step_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_full_half_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !half_n);

  p_empty_hold_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && !rd_en_n && retx_n) |=> $stable(rptr));

  p_retx_clear_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !retx_n |=> (rptr == '0));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .load_n(load_n), .retx_n(retx_n),
  .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
  .wptr(wptr), .wgray(wgray), .rptr(rptr)
);

// File: tb/tb_dcfifo_pflag.sv
module tb_dcfifo_pflag;
  localparam int DEPTH = 16;
  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic wr_en_n = 1, rd_en_n = 1, load_n = 1, retx_n = 1, async_flags = 0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic empty_n, full_n, half_n, aempty_n, afull_n;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [17:0] q[$];
  event got;

  always #4 wr_clk = ~wr_clk;
  always #5 rd_clk = ~rd_clk;

  dcfifo_pflag #(.WIDTH(18), .DEPTH(DEPTH), .OFF_RST(7)) dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .din(din),
    .rd_en_n(rd_en_n), .dout(dout), .load_n(load_n), .retx_n(retx_n),
    .async_flags(async_flags), .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n));

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [17:0] d, bit push);
    @(negedge wr_clk); wr_en_n = 0; din = d;
    @(negedge wr_clk); wr_en_n = 1;
    if (push) q.push_back(d);
  endtask

  task automatic rd_word();
    @(negedge rd_clk); rd_en_n = 0;
    @(negedge rd_clk); rd_en_n = 1;
    ->got;
    #1;
  endtask

  task automatic rd_raw(output logic [17:0] v);
    @(negedge rd_clk); rd_en_n = 0;
    @(negedge rd_clk); rd_en_n = 1; v = dout;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic load_wr(logic [17:0] d);
    load_n = 0; wr_word(d, 0); load_n = 1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin : monitor
    forever begin
      @(got);
      if (q.size() == 0) chk("R2 unexpected word", dout, 18'h0);
      else chk("R2 order", dout, q.pop_front());
    end
  end

  initial begin : watchdog
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin : stim
    logic [17:0] v, last;
    logic [17:0] hist[$];
    #23 rst_n = 1;
    settle();
    chk("R1 empty_n", empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 half_n", half_n, 1);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 afull_n", afull_n, 1);
    load_n = 0;
    rd_raw(v); chk("R1 R6 empty offset reset", v, 18'd7);
    rd_raw(v); chk("R1 R6 full offset reset", v, 18'd7);
    load_n = 1;

    // R11 retransmit replay from first location
    for (int i = 0; i < 4; i++) begin
      wr_word(18'h100 + 18'(i), 1);
      hist.push_back(18'h100 + 18'(i));
    end
    settle();
    rd_word(); rd_word();
    @(negedge rd_clk); retx_n = 0;
    @(negedge rd_clk); retx_n = 1;
    q = hist;
    settle();
    chk("R11 not empty after retransmit", empty_n, 1);
    for (int i = 0; i < 4; i++) rd_word();
    settle();
    chk("R11 empty after replay", empty_n, 0);

    // R2 basic order
    for (int i = 0; i < 3; i++) wr_word(18'h2A5A0 + 18'(i), 1);
    settle();
    chk("R2 empty_n", empty_n, 1);
    chk("R7 aempty_n level 3", aempty_n, 0);
    for (int i = 0; i < 3; i++) rd_word();
    settle();
    chk("R2 empty_n drained", empty_n, 0);

    // R4 read while empty ignored
    last = dout;
    rd_raw(v);
    chk("R4 dout held", v, last);
    wr_word(18'h3C3C3, 1);
    settle();
    rd_word();
    settle();

    // R7 R8 R10 R3 threshold walk
    for (int i = 0; i < 8; i++) wr_word(18'h01000 + 18'(i), 1);
    settle();
    chk("R7 aempty_n level 8", aempty_n, 1);
    chk("R10 half_n level 8", half_n, 1);
    chk("R8 afull_n level 8", afull_n, 1);
    wr_word(18'h01008, 1);
    settle();
    chk("R10 half_n level 9", half_n, 0);
    chk("R8 afull_n level 9", afull_n, 0);
    for (int i = 9; i < 16; i++) wr_word(18'h01000 + 18'(i), 1);
    settle();
    chk("R3 full_n", full_n, 0);
    wr_word(18'h0DEAD, 0);
    settle();
    chk("R3 full_n still", full_n, 0);
    for (int i = 0; i < 16; i++) rd_word();
    settle();
    chk("R3 drained empty", empty_n, 0);
    chk("R3 full_n released", full_n, 1);

    // R5 R6 offset load
    load_wr(18'd3);
    load_wr(18'd12);
    load_n = 0;
    rd_raw(v); chk("R6 empty offset", v, 18'd3);
    rd_raw(v); chk("R6 full offset", v, 18'd12);
    load_n = 1;
    settle();
    chk("R5 load did not store data", empty_n, 0);
    for (int i = 0; i < 4; i++) wr_word(18'h02000 + 18'(i), 1);
    settle();
    chk("R5 R7 aempty_n with offset 3", aempty_n, 1);
    chk("R5 R8 afull_n with offset 12", afull_n, 0);
    for (int i = 0; i < 4; i++) rd_word();
    settle();

    // R9 timing modes
    for (int i = 0; i < 3; i++) wr_word(18'h03000 + 18'(i), 1);
    settle();
    chk("R9 sync aempty_n level 3", aempty_n, 0);
    @(negedge wr_clk); wr_en_n = 0; din = 18'h03003; q.push_back(18'h03003);
    @(posedge wr_clk); #1;
    chk("R9 sync aempty_n lags", aempty_n, 0);
    @(negedge wr_clk); wr_en_n = 1;
    settle();
    chk("R9 sync aempty_n settled", aempty_n, 1);
    for (int i = 0; i < 4; i++) rd_word();
    settle();
    async_flags = 1;
    for (int i = 0; i < 3; i++) wr_word(18'h04000 + 18'(i), 1);
    settle();
    chk("R9 async aempty_n level 3", aempty_n, 0);
    @(negedge wr_clk); wr_en_n = 0; din = 18'h04003; q.push_back(18'h04003);
    @(posedge wr_clk); #1;
    chk("R9 async aempty_n immediate", aempty_n, 1);
    @(negedge wr_clk); wr_en_n = 1;
    for (int i = 0; i < 4; i++) rd_word();
    settle();
    chk("R2 final empty", empty_n, 0);
    chk("R2 queue consumed", 18'(q.size()), 18'd0);
    finish_up();
  end
endmodule